// File: doc/BRIEF.md
# Front Panel Run and Examine Sequencer

This block sits between a set of operator switches and a stalled processor. It drives the processor's ready input and holds it low whenever no operator action is in progress. When the machine is stopped, a switch request starts one of several actions. RUN lets the processor run freely. STEP releases it for a single machine cycle. EXAMINE or EXAMINE-NEXT feeds it instruction bytes directly, and DEPOSIT or DEPOSIT-NEXT writes the data switches into memory. Instruction bytes are fed by placing a byte on a jam path that overrides the processor's input data bus while the processor strobes its data-input line.

EXAMINE feeds an unconditional jump built from the sixteen address switches. The processor therefore loads the switch address into its program counter and then stops. EXAMINE-NEXT feeds a single no-op, which advances the program counter by one. DEPOSIT issues one memory write with the eight data switches as the write data. DEPOSIT-NEXT performs an EXAMINE-NEXT first and then a DEPOSIT.

All switch inputs are clean one-cycle pulses that are synchronous to `clk`. The processor's SYNC, phase-2, M1 status and data-input strobe are sampled on the same clock.

Top module: `fp_panel_seq`

## Requirements
- R1: `cpu_ready` is high exactly when one of four activities is in progress: run, single step, examine or examine-next. At most one of these four activities is in progress at any time.
- R2: A stop pulse that arrives while running is remembered. Run ends on the first clock edge where `cpu_sync`, `cpu_phi2` and `cpu_m1` are all high, so `cpu_ready` falls after that edge. A stop pulse that arrives while stopped is not remembered.
- R3: Every switch except stop is ignored unless the block is fully idle. Fully idle means no run, no step, no examine or examine-next, and no pending or active write. A request that arrives during a sequence has no effect.
- R4: A step pulse raises `cpu_ready` and `step_ind` from the next cycle onward. Both stay high until the clock edge that first sees a rising edge of `cpu_sync`, and they are low after that edge.
- R5: Examine advances one byte per falling edge of `cpu_dbin`. The first byte is the jump opcode 0xC3, which is all-ones with data bits 2 to 5 pulled low. The second byte is `addr_sw[7:0]` and the third is `addr_sw[15:8]`. After the third strobe ends, `cpu_ready` is low.
- R6: `jam_en` is high only while `cpu_dbin` is high during an examine or examine-next. When `cpu_dbin` is low, `jam_en` is low.
- R7: Examine-next jams a single 0x00 byte (every data line pulled low). `cpu_ready` is low after that strobe ends.
- R8: A deposit produces exactly one `mem_wr` pulse, one cycle long, in the cycle after the switch pulse. While `mem_wr` is high, `jam_data` equals `data_sw`.
- R9: Deposit-next jams one 0x00 byte. In the cycle after that strobe ends, it produces one single-cycle `mem_wr` pulse carrying `data_sw`.
- R10: While reset is held and right after reset, `cpu_ready`, `jam_en`, `mem_wr`, `run_ind` and `step_ind` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_run | input | 1 | Run request pulse |
| sw_stop | input | 1 | Stop request pulse |
| sw_step | input | 1 | Single-step request pulse |
| sw_exam | input | 1 | Examine request pulse |
| sw_exnext | input | 1 | Examine-next request pulse |
| sw_dep | input | 1 | Deposit request pulse |
| sw_depnext | input | 1 | Deposit-next request pulse |
| cpu_sync | input | 1 | Processor machine-cycle start marker |
| cpu_phi2 | input | 1 | Phase-2 clock level |
| cpu_m1 | input | 1 | Status bit: opcode fetch cycle |
| cpu_dbin | input | 1 | Processor data-input strobe |
| addr_sw | input | 16 | Address switches |
| data_sw | input | 8 | Data switches |
| cpu_ready | output | 1 | Ready to the processor |
| jam_data | output | 8 | Byte forced onto the data path |
| jam_en | output | 1 | Enables the jammed byte onto the input bus |
| mem_wr | output | 1 | Memory write pulse |
| run_ind | output | 1 | Run indication |
| step_ind | output | 1 | Single-step indication |

## Verification
The hardest situation to reach from the ports is a stop request that has been remembered but is waiting on the fetch qualifier. The bench drives SYNC and phase-2 high with M1 low and confirms that run persists. It then raises M1 and confirms that run ends on that edge. It also presses stop while stopped and then starts a run, which shows that the earlier pulse left nothing behind. A second hard case is a request that arrives in the middle of an examine. The bench presses step between DBIN strobes and then checks that the jammed byte stream continues unchanged.

// File: rtl/fp_panel_pkg.sv
package fp_panel_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    // jump opcode: idle-high bus with a run of lines pulled low
    localparam int PULL_LSB = 2;
    localparam int PULL_MSB = 5;
    localparam logic [DW-1:0] JMP_PULL_MASK =
        DW'(((1 << (PULL_MSB - PULL_LSB + 1)) - 1) << PULL_LSB);
    localparam logic [DW-1:0] JMP_OPCODE = ~JMP_PULL_MASK;
    localparam logic [DW-1:0] NOP_OPCODE = '0;

    typedef enum logic [1:0] {
        STEP_IDLE    = 2'd0,
        STEP_OPCODE  = 2'd1,
        STEP_ADDR_LO = 2'd2,
        STEP_ADDR_HI = 2'd3
    } exam_step_e;

endpackage

// File: rtl/fp_runstep_ctl.sv
module fp_runstep_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic stopped,
    input  logic sw_run,
    input  logic sw_stop,
    input  logic sw_step,
    input  logic cpu_sync,
    input  logic cpu_phi2,
    input  logic cpu_m1,
    output logic run_o,
    output logic step_o
);

    typedef struct packed {
        logic run;
        logic stop_req;
        logic step;
        logic sync_prev;
    } rs_state_t;

    rs_state_t st_q, st_d;

    logic stop_window;
    logic sync_rise;

    assign stop_window = cpu_sync & cpu_phi2 & cpu_m1;
    assign sync_rise   = cpu_sync & ~st_q.sync_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sync_prev = cpu_sync;

        if (stopped && sw_run) begin
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            if ((st_q.stop_req || sw_stop) && stop_window) begin
                st_d.run      = 1'b0;
                st_d.stop_req = 1'b0;
            end else if (sw_stop) begin
                st_d.stop_req = 1'b1;
            end
        end

        if (stopped && sw_step) begin
            st_d.step = 1'b1;
        end else if (st_q.step && sync_rise) begin
            st_d.step = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign step_o = st_q.step;

    AST_STOP_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(cpu_sync && cpu_phi2 && cpu_m1)); // R2

    AST_STEP_ENDS_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.step) |-> $past(cpu_sync)); // R4

endmodule

// File: rtl/fp_jam_seq.sv
module fp_jam_seq
    import fp_panel_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stopped,
    input  logic          sw_exam,
    input  logic          sw_exnext,
    input  logic          sw_dep,
    input  logic          sw_depnext,
    input  logic          cpu_dbin,
    input  logic [AW-1:0] addr_sw,
    input  logic [DW-1:0] data_sw,
    output logic          exam_o,
    output logic          exnext_o,
    output logic          busy_o,
    output logic [DW-1:0] jam_data,
    output logic          jam_en,
    output logic          mem_wr
);

    typedef struct packed {
        logic       exam;
        exam_step_e cnt;
        logic       exnext;
        logic       dep_pend;
        logic       wr;
        logic       dbin_prev;
    } js_state_t;

    js_state_t st_q, st_d;

    logic dbin_fall;
    assign dbin_fall = st_q.dbin_prev & ~cpu_dbin;

    always_comb begin
        st_d           = st_q;
        st_d.dbin_prev = cpu_dbin;
        st_d.wr        = 1'b0;

        if (stopped) begin
            if (sw_exam) begin
                st_d.exam = 1'b1;
                st_d.cnt  = STEP_OPCODE;
            end else if (sw_exnext) begin
                st_d.exnext = 1'b1;
            end else if (sw_depnext) begin
                st_d.exnext   = 1'b1;
                st_d.dep_pend = 1'b1;
            end else if (sw_dep) begin
                st_d.wr = 1'b1;
            end
        end

        if (st_q.exam && dbin_fall) begin
            if (st_q.cnt == STEP_ADDR_HI) begin
                st_d.exam = 1'b0;
                st_d.cnt  = STEP_IDLE;
            end else begin
                st_d.cnt = exam_step_e'(st_q.cnt + 2'd1);
            end
        end

        if (st_q.exnext && dbin_fall) begin
            st_d.exnext = 1'b0;
            if (st_q.dep_pend) begin
                st_d.dep_pend = 1'b0;
                st_d.wr       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        jam_data = '1;
        if (st_q.wr) begin
            jam_data = data_sw;
        end else if (st_q.exnext) begin
            jam_data = NOP_OPCODE;
        end else if (st_q.exam) begin
            case (st_q.cnt)
                STEP_OPCODE:  jam_data = JMP_OPCODE;
                STEP_ADDR_LO: jam_data = addr_sw[DW-1:0];
                STEP_ADDR_HI: jam_data = addr_sw[AW-1:DW];
                default:      jam_data = '1;
            endcase
        end
    end

    assign jam_en   = (st_q.exam | st_q.exnext) & cpu_dbin;
    assign mem_wr   = st_q.wr;
    assign exam_o   = st_q.exam;
    assign exnext_o = st_q.exnext;
    assign busy_o   = st_q.exam | st_q.exnext | st_q.dep_pend | st_q.wr;

    AST_EXAM_ENDS_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.exam) |-> $past(st_q.cnt == STEP_ADDR_HI)); // R5

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |=> !st_q.wr); // R8

    AST_WR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wr) |-> $past(stopped || (st_q.exnext && st_q.dep_pend))); // R9

endmodule

// File: rtl/fp_panel_seq.sv
module fp_panel_seq
    import fp_panel_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_run,
    input  logic          sw_stop,
    input  logic          sw_step,
    input  logic          sw_exam,
    input  logic          sw_exnext,
    input  logic          sw_dep,
    input  logic          sw_depnext,
    input  logic          cpu_sync,
    input  logic          cpu_phi2,
    input  logic          cpu_m1,
    input  logic          cpu_dbin,
    input  logic [AW-1:0] addr_sw,
    input  logic [DW-1:0] data_sw,
    output logic          cpu_ready,
    output logic [DW-1:0] jam_data,
    output logic          jam_en,
    output logic          mem_wr,
    output logic          run_ind,
    output logic          step_ind
);

    logic run_w, step_w, exam_w, exnext_w, seq_busy_w;
    logic stopped;

    assign stopped = ~(run_w | step_w | seq_busy_w);

    fp_runstep_ctl i_runstep (
        .clk      (clk),
        .rst_n    (rst_n),
        .stopped  (stopped),
        .sw_run   (sw_run),
        .sw_stop  (sw_stop),
        .sw_step  (sw_step),
        .cpu_sync (cpu_sync),
        .cpu_phi2 (cpu_phi2),
        .cpu_m1   (cpu_m1),
        .run_o    (run_w),
        .step_o   (step_w)
    );

    fp_jam_seq i_jamseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stopped    (stopped),
        .sw_exam    (sw_exam),
        .sw_exnext  (sw_exnext),
        .sw_dep     (sw_dep),
        .sw_depnext (sw_depnext),
        .cpu_dbin   (cpu_dbin),
        .addr_sw    (addr_sw),
        .data_sw    (data_sw),
        .exam_o     (exam_w),
        .exnext_o   (exnext_w),
        .busy_o     (seq_busy_w),
        .jam_data   (jam_data),
        .jam_en     (jam_en),
        .mem_wr     (mem_wr)
    );

    assign cpu_ready = run_w | step_w | exam_w | exnext_w;
    assign run_ind   = run_w;
    assign step_ind  = step_w;

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_w, step_w, exam_w, exnext_w})); // R1

    AST_WR_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !cpu_ready); // R3

endmodule

// File: tb/test_fp_panel_seq.sv
module test_fp_panel_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_run = 0, sw_stop = 0, sw_step = 0, sw_exam = 0;
    logic sw_exnext = 0, sw_dep = 0, sw_depnext = 0;
    logic cpu_sync = 0, cpu_phi2 = 0, cpu_m1 = 0, cpu_dbin = 0;
    logic [15:0] addr_sw = '0;
    logic [7:0]  data_sw = '0;
    logic        cpu_ready, jam_en, mem_wr, run_ind, step_ind;
    logic [7:0]  jam_data;

    int total = 0;
    int bad = 0;

    typedef struct {
        bit         is_wr;
        logic [7:0] val;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    fp_panel_seq i_fp_panel_seq (
        .clk(clk), .rst_n(rst_n),
        .sw_run(sw_run), .sw_stop(sw_stop), .sw_step(sw_step),
        .sw_exam(sw_exam), .sw_exnext(sw_exnext), .sw_dep(sw_dep),
        .sw_depnext(sw_depnext),
        .cpu_sync(cpu_sync), .cpu_phi2(cpu_phi2), .cpu_m1(cpu_m1),
        .cpu_dbin(cpu_dbin), .addr_sw(addr_sw), .data_sw(data_sw),
        .cpu_ready(cpu_ready), .jam_data(jam_data), .jam_en(jam_en),
        .mem_wr(mem_wr), .run_ind(run_ind), .step_ind(step_ind)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic press(input int which);
        case (which)
            0: sw_run = 1;     1: sw_stop = 1;   2: sw_step = 1;
            3: sw_exam = 1;    4: sw_exnext = 1; 5: sw_dep = 1;
            default: sw_depnext = 1;
        endcase
        tick();
        {sw_run, sw_stop, sw_step, sw_exam, sw_exnext, sw_dep, sw_depnext} = '0;
    endtask

    task automatic strobe();
        cpu_dbin = 1;
        tick();
        tick();
        cpu_dbin = 0;
        tick();
    endtask

    task automatic push_exp(input bit is_wr, input logic [7:0] v, input string tag);
        exp_item_t it;
        it.is_wr = is_wr;
        it.val   = v;
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    // monitor: pops an expected item on each jam start and each write pulse
    logic jam_prev = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && ((jam_en && !jam_prev) || mem_wr)) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected output actual=%h expected=none", jam_data);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    if (it.is_wr !== mem_wr || it.val !== jam_data) begin
                        bad++;
                        $display("FAIL %s actual=%h/wr%0b expected=%h/wr%0b",
                                 it.tag, jam_data, mem_wr, it.val, it.is_wr);
                    end
                end
            end
            jam_prev = jam_en;
        end
    end

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick();
        // R10 reset state
        check({cpu_ready, jam_en, mem_wr, run_ind, step_ind}, 0, "R10 during reset");
        rst_n = 1;
        tick();
        check({cpu_ready, jam_en, mem_wr, run_ind, step_ind}, 0, "R10 after reset");

        // R5 examine with address 0x12F0
        addr_sw = 16'h12F0;
        push_exp(0, 8'hC3, "R5 jump opcode");
        push_exp(0, 8'hF0, "R5 address low");
        push_exp(0, 8'h12, "R5 address high");
        press(3);
        check(cpu_ready, 1, "R1 ready during examine");
        check(jam_en, 0, "R6 no jam without dbin");
        strobe();
        press(2); // R3 step ignored mid-sequence
        check(step_ind, 0, "R3 step ignored during examine");
        check(cpu_ready, 1, "R5 still examining");
        strobe();
        strobe();
        check(cpu_ready, 0, "R5 ready low after third byte");
        check(jam_en, 0, "R6 jam off after examine");

        // R7 examine-next
        push_exp(0, 8'h00, "R7 nop byte");
        press(4);
        check(cpu_ready, 1, "R7 ready during examine-next");
        strobe();
        check(cpu_ready, 0, "R7 ready low after nop");

        // R8 deposit
        data_sw = 8'h5A;
        push_exp(1, 8'h5A, "R8 deposit data");
        press(5);
        check(mem_wr, 1, "R8 write pulse");
        tick();
        check(mem_wr, 0, "R8 pulse one cycle");

        // R9 deposit-next
        data_sw = 8'hA7;
        push_exp(0, 8'h00, "R9 nop byte");
        push_exp(1, 8'hA7, "R9 deposit data");
        press(6);
        check(mem_wr, 0, "R9 no write before strobe");
        strobe();
        check(mem_wr, 1, "R9 write after nop");
        check(cpu_ready, 0, "R9 ready low at write");
        tick();
        check(mem_wr, 0, "R9 write one cycle");

        // R4 single step
        press(2);
        check({step_ind, cpu_ready}, 2'b11, "R4 step active");
        tick();
        tick();
        check(step_ind, 1, "R4 step holds without sync");
        cpu_sync = 1;
        tick();
        check({step_ind, cpu_ready}, 2'b00, "R4 step cleared by sync");
        cpu_sync = 0;
        tick();

        // R1/R3 run, examine ignored while running
        press(0);
        check({run_ind, cpu_ready}, 2'b11, "R1 ready while running");
        press(3);
        cpu_dbin = 1;
        tick();
        check(jam_en, 0, "R3 examine ignored while running");
        cpu_dbin = 0;
        tick();

        // R2 stop waits for the fetch qualifier
        press(1);
        check(run_ind, 1, "R2 run held after stop press");
        cpu_sync = 1; cpu_phi2 = 1; cpu_m1 = 0;
        tick();
        check(run_ind, 1, "R2 no stop without M1");
        cpu_m1 = 1;
        tick();
        check({run_ind, cpu_ready}, 2'b00, "R2 stop at fetch");
        cpu_sync = 0; cpu_phi2 = 0; cpu_m1 = 0;
        tick();

        // R2 stop while stopped is not remembered
        press(1);
        press(0);
        cpu_sync = 1; cpu_phi2 = 1; cpu_m1 = 1;
        tick();
        check(run_ind, 1, "R2 stale stop not remembered");
        cpu_sync = 0; cpu_phi2 = 0; cpu_m1 = 0;
        press(1);
        cpu_sync = 1; cpu_phi2 = 1; cpu_m1 = 1;
        tick();
        check(run_ind, 0, "R2 second stop");
        cpu_sync = 0; cpu_phi2 = 0; cpu_m1 = 0;
        tick();

        // R5 examine with a second address pattern
        addr_sw = 16'h8001;
        push_exp(0, 8'hC3, "R5 jump opcode 2");
        push_exp(0, 8'h01, "R5 address low 2");
        push_exp(0, 8'h80, "R5 address high 2");
        press(3);
        strobe();
        strobe();
        strobe();
        check(cpu_ready, 0, "R5 second examine ends");
        tick();
        check(exp_q.size(), 0, "R5 all expected bytes seen");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule